// File: doc/BRIEF.md
# Hierarchical Reset Controller

This block produces the reset outputs of a small multi-port network device and arranges them in three tiers. A chip-level request, either a power-on event or the external active-low reset pin, clears everything, including the block's own control state. A software digital reset clears the core logic, which is every sub-module except the three PHY blocks. A single-module reset clears one PHY: the first port PHY, the second port PHY or the virtual PHY.

Software starts resets in two ways. It can write a 4-bit reset control word. It can also write a 16-bit basic control word addressed to one PHY, where bit 15 requests that PHY's reset. Every request bit clears itself. It reads back as 1 while the pulse it started is in progress, and returns to 0 when that pulse ends.

A chip-level request asserts every output at once. Its release passes through a synchronizer and is then stretched. Each software pulse is registered, lasts a fixed number of system clock cycles and ends on a clock edge.

Top module: `rst_tier_ctrl`

## Requirements
- R1: While `por_i` is 1 or `rst_ni` is 0, `core_rst_no` and all bits of `phy_rst_no` are 0. They go low without waiting for a clock edge.
- R2: After the last chip-level request ends, all outputs stay low until the rising edge numbered SYNC_STAGES+PULSE_LEN (2+16=18) after the request ended, and they go high on that edge. Once high, they stay high until the next request.
- R3: A chip-level request clears `ctl_rdata_o` and `phy_bc_rst_o` to 0. Software writes made while the chip-level reset is still held have no effect.
- R4: A write with `ctl_wdata_i` bit 0 set (digital reset) drives `core_rst_no` low from the write edge for exactly PULSE_LEN (16) cycles. `phy_rst_no` is left unchanged.
- R5: `ctl_wdata_i` bits 1, 2 and 3 start a PULSE_LEN-cycle pulse on `phy_rst_no[0]` (first port PHY), `phy_rst_no[1]` (second port PHY) and `phy_rst_no[2]` (virtual PHY) respectively. `core_rst_no` is left unchanged.
- R6: A write with `phy_bc_we_i[k]` = 1 and `phy_bc_wdata_i[15]` = 1 starts the PULSE_LEN-cycle pulse on `phy_rst_no[k]` only. If bit 15 is 0, the write has no effect.
- R7: `ctl_rdata_o` bit 0 reads 1 while the digital pulse is active. Bit k+1 of `ctl_rdata_o` and bit k of `phy_bc_rst_o` read 1 while PHY k's pulse is active, whichever path started it. Both return to 0 when the pulse ends.
- R8: Writing 1 to a bit whose pulse is already active does not change that pulse's end cycle. Writing 0 has no effect.
- R9: When one control write sets several bits, the pulses for those bits start and end on the same edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | External reset pin, active low, asynchronous |
| por_i | input | 1 | Power-on event, active high, asynchronous |
| ctl_we_i | input | 1 | Write strobe for the reset control word |
| ctl_wdata_i | input | 4 | Control write data: bit 0 digital, bits 1..3 PHY 0..2 |
| ctl_rdata_o | output | 4 | Control readback, 1 while the pulse of that bit is active |
| phy_bc_we_i | input | 3 | Per-PHY write strobe for the basic control word |
| phy_bc_wdata_i | input | 16 | Basic control write data, bit 15 requests a reset |
| phy_bc_rst_o | output | 3 | Per-PHY readback of bit 15 |
| core_rst_no | output | 1 | Reset for all non-PHY sub-modules, active low |
| phy_rst_no | output | 3 | Per-PHY reset, active low: first port, second port, virtual |

## Verification
The clocked properties are disabled while the internal chip-level hold is active. They therefore assume that `por_i` and `rst_ni` reach the pulse logic only through that hold, and that write strobes are sampled only at rising edges. The pulse-length properties also assume that no chip-level request cuts a software pulse short. The only exception is the scenario built for that case, which the property's reset disable covers. The bench changes every input on the falling clock edge and raises each write strobe for exactly one rising edge. It sweeps all sixteen control words and all three PHY basic-control paths with bit 15 both set and clear. It applies the asynchronous requests between edges, with their widths chosen so that no edge sees a partial request.

// File: rtl/rst_tier_pkg.sv
package rst_tier_pkg;
  localparam int unsigned N_PHY       = 3;
  localparam int unsigned CTL_W       = N_PHY + 1;
  localparam int unsigned CTL_DIG_BIT = 0;
  localparam int unsigned CTL_PHY_LSB = 1;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic req_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  // assert asynchronously, release through STAGES flops
  always_ff @(posedge clk_i or negedge req_ni) begin
    if (!req_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic hold_no
);
  localparam int unsigned CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q   <= CNT_W'(LEN);
      hold_no <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      hold_no <= (cnt_d == '0);
    end
  end

  // checker: cycles spent low since synchronized release
  logic [CNT_W-1:0] lo_run_q;
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)                                   lo_run_q <= '0;
    else if (!hold_no && lo_run_q != CNT_W'(LEN))   lo_run_q <= lo_run_q + 1'b1;
  end

  // R2
  stretch_len_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(hold_no) |-> lo_run_q == CNT_W'(LEN));
  // R2
  stretch_stay_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    hold_no |=> hold_no);
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // a trigger during an active pulse is ignored
  always_comb begin
    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else if (trig_i) cnt_d = CNT_W'(LEN);
    else             cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_o <= (cnt_d != '0);
    end
  end

  // checker: length of the current pulse
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)                               run_q <= '0;
    else if (!busy_o)                           run_q <= '0;
    else if (run_q != CNT_W'(LEN))              run_q <= run_q + 1'b1;
  end

  // R4 R5
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $fell(busy_o) |-> run_q == CNT_W'(LEN));
  // R8
  retrig_ignored_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (busy_o && trig_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R7
  start_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (trig_i && !busy_o) |=> busy_o && cnt_q == CNT_W'(LEN));
endmodule

// File: rtl/rst_tier_ctrl.sv
module rst_tier_ctrl
  import rst_tier_pkg::*;
#(
  parameter int unsigned PULSE_LEN   = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BC_W        = 16,
  parameter int unsigned BC_RST_BIT  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o,
  input  logic [N_PHY-1:0] phy_bc_we_i,
  input  logic [BC_W-1:0]  phy_bc_wdata_i,
  output logic [N_PHY-1:0] phy_bc_rst_o,
  output logic             core_rst_no,
  output logic [N_PHY-1:0] phy_rst_no
);
  logic chip_req_n, sync_n, hold_n;
  logic dig_busy;
  logic [N_PHY-1:0] phy_busy, phy_trig;
  logic unused_bc;

  assign chip_req_n = rst_ni & ~por_i;
  assign unused_bc  = ^phy_bc_wdata_i;

  rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .req_ni (chip_req_n),
    .rst_no (sync_n)
  );

  rst_stretch #(.LEN(PULSE_LEN)) i_stretch (
    .clk_i   (clk_i),
    .arst_ni (sync_n),
    .hold_no (hold_n)
  );

  rst_pulse_gen #(.LEN(PULSE_LEN)) i_dig_pulse (
    .clk_i   (clk_i),
    .arst_ni (hold_n),
    .trig_i  (ctl_we_i & ctl_wdata_i[CTL_DIG_BIT]),
    .busy_o  (dig_busy)
  );

  for (genvar k = 0; k < N_PHY; k++) begin : g_phy
    assign phy_trig[k] = (ctl_we_i & ctl_wdata_i[CTL_PHY_LSB+k])
                       | (phy_bc_we_i[k] & phy_bc_wdata_i[BC_RST_BIT]);

    rst_pulse_gen #(.LEN(PULSE_LEN)) i_phy_pulse (
      .clk_i   (clk_i),
      .arst_ni (hold_n),
      .trig_i  (phy_trig[k]),
      .busy_o  (phy_busy[k])
    );

    assign phy_rst_no[k]   = hold_n & ~phy_busy[k];
    assign phy_bc_rst_o[k] = phy_busy[k];

    // R6
    bc_start_chk: assert property (@(posedge clk_i) disable iff (!hold_n)
      (phy_bc_we_i[k] && phy_bc_wdata_i[BC_RST_BIT] && !phy_bc_rst_o[k])
      |=> !phy_rst_no[k]);
  end

  assign core_rst_no = hold_n & ~dig_busy;
  assign ctl_rdata_o = {phy_busy, dig_busy};

  // R4
  dig_spares_phy_chk: assert property (@(posedge clk_i) disable iff (!hold_n)
    (ctl_we_i && ctl_wdata_i[CTL_W-1:CTL_PHY_LSB] == '0 && phy_bc_we_i == '0
     && phy_rst_no == '1) |=> phy_rst_no == '1);
  // R4
  dig_start_chk: assert property (@(posedge clk_i) disable iff (!hold_n)
    (ctl_we_i && ctl_wdata_i[CTL_DIG_BIT] && !ctl_rdata_o[CTL_DIG_BIT])
    |=> !core_rst_no && ctl_rdata_o[CTL_DIG_BIT]);
  // R5
  phy_spares_core_chk: assert property (@(posedge clk_i) disable iff (!hold_n)
    (!ctl_we_i && core_rst_no) |=> core_rst_no);
endmodule

// File: tb/test_rst_tier_ctrl.sv
`timescale 1ns/1ps
module test_rst_tier_ctrl;
  localparam int LEN  = 16;
  localparam int SYNC = 2;
  localparam int CHIP_LOWS = SYNC + LEN - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por = 1'b1, ctl_we = 1'b0;
  logic [3:0]  ctl_wdata = '0, ctl_rdata;
  logic [2:0]  bc_we = '0, bc_rst, phy_rst_n;
  logic [15:0] bc_wdata = '0;
  logic        core_rst_n;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rst_tier_ctrl i_rst_tier_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .phy_bc_we_i(bc_we), .phy_bc_wdata_i(bc_wdata), .phy_bc_rst_o(bc_rst),
    .core_rst_no(core_rst_n), .phy_rst_no(phy_rst_n)
  );

  function automatic logic [3:0] low_vec();
    return {~phy_rst_n, ~core_rst_n};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; the write covers one rising edge
  task automatic ctl_write(input logic [3:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic bc_write(input int k, input logic [15:0] d);
    bc_we = 3'(1 << k); bc_wdata = d;
    @(negedge clk);
    bc_we = '0; bc_wdata = '0;
  endtask

  // samples with any reset low, counting the current one
  task automatic lows_now(output int n);
    n = 0;
    while (low_vec() != 4'h0 && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  // samples with any reset low, starting at the next falling edge
  task automatic lows_next(output int n);
    n = 0;
    @(negedge clk);
    while (low_vec() != 4'h0 && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 all low at power-on", low_vec(), 4'hf);
    chk("R3 ctl_rdata cleared", ctl_rdata, 0);
    chk("R3 bc readback cleared", bc_rst, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 por alone holds reset", low_vec(), 4'hf);
    por = 1'b0;
    lows_next(n);
    chk("R2 release after por", n, CHIP_LOWS);

    // reset pin path, asynchronous assertion
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 pin asserts without clock", low_vec(), 4'hf);
    @(negedge clk);
    rst_n = 1'b1;
    lows_next(n);
    chk("R2 release after pin", n, CHIP_LOWS);
    repeat (2) @(negedge clk);
    chk("R2 outputs stay high", low_vec(), 0);

    // writes while the chip hold is still active are ignored
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    repeat (4) @(negedge clk);
    ctl_write(4'hf);
    bc_write(2, 16'h8000);
    repeat (30) @(negedge clk);
    chk("R3 writes during hold ignored", low_vec(), 0);
    chk("R3 ctl_rdata after hold", ctl_rdata, 0);

    // all control words
    for (int v = 0; v < 16; v++) begin
      ctl_write(4'(v));
      chk($sformatf("R4 R5 R9 pattern v=%0d", v), low_vec(), v);
      chk($sformatf("R7 ctl readback v=%0d", v), ctl_rdata, v);
      chk($sformatf("R7 bc readback v=%0d", v), bc_rst, v >> 1);
      lows_now(n);
      chk($sformatf("R4 R5 R9 pulse len v=%0d", v), n, (v != 0) ? LEN : 0);
      chk($sformatf("R7 self clear v=%0d", v), ctl_rdata, 0);
      repeat (2) @(negedge clk);
    end

    // basic control path per PHY
    for (int k = 0; k < 3; k++) begin
      for (int d = 0; d < 3; d++) begin
        logic [15:0] w;
        w = (d == 0) ? 16'h8000 : (d == 1) ? 16'h7fff : 16'hffff;
        bc_write(k, w);
        chk($sformatf("R6 bc k=%0d w=%0h", k, w), low_vec(),
            w[15] ? (2 << k) : 0);
        chk($sformatf("R7 bc readback k=%0d", k), bc_rst, w[15] ? (1 << k) : 0);
        chk($sformatf("R7 ctl readback k=%0d", k), ctl_rdata, w[15] ? (2 << k) : 0);
        lows_now(n);
        chk($sformatf("R6 pulse len k=%0d", k), n, w[15] ? LEN : 0);
        repeat (2) @(negedge clk);
      end
    end

    // retrigger during an active pulse
    ctl_write(4'h1);
    repeat (5) @(negedge clk);
    ctl_write(4'h1);
    lows_now(n);
    chk("R8 retrigger keeps end cycle", n, LEN - 6);
    repeat (2) @(negedge clk);

    // zero write and bc retrigger
    bc_write(1, 16'h8000);
    repeat (3) @(negedge clk);
    ctl_write(4'h0);
    bc_write(1, 16'h8000);
    lows_now(n);
    chk("R8 zero write and bc retrigger", n, LEN - 5);
    repeat (2) @(negedge clk);

    // chip reset during a pulse
    ctl_write(4'he);
    repeat (3) @(negedge clk);
    por = 1'b1;
    @(negedge clk);
    chk("R3 chip reset clears readback", ctl_rdata, 0);
    chk("R1 chip reset mid pulse", low_vec(), 4'hf);
    por = 1'b0;
    lows_next(n);
    chk("R2 release after mid-pulse reset", n, CHIP_LOWS);
    chk("R3 no leftover pulse", ctl_rdata, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule